// File: doc/BRIEF.md
# Fractional-Divisor Oversampling Serial Receiver

This block receives asynchronous serial frames with one start bit, eight data bits and one stop bit, and no parity. It runs from a fast input clock. A programmable divisor sets the bit period. The divisor has a whole part and a fractional part in sixteenths. Each bit is split into sixteen equal subdivisions of D input clocks each, where D is the divisor. Three sample instants near mid-bit are taken as the truncated products of D with 7, 8 and 9. When the fraction is nonzero these instants are unevenly spaced.

A two-out-of-three vote decides each bit. The block presents the received byte with a one-cycle strobe, together with a framing-error flag and a noise flag. The noise flag reports that, somewhere in the frame, the three samples of a bit did not agree. The divisor inputs should be held steady while a frame is in flight.

Top module: `frac_uart_rx`

## Requirements
- R1: The divisor is a 12-bit whole part `div_mant` and a 4-bit fraction `div_frac` in units of 1/16. The bit period is 16*M+F input clocks, where M is `div_mant` and F is `div_frac`. A whole part of 0 is treated as 1, so M=0 with F=8 gives a 24-clock bit.
- R2: Within a bit, samples are taken at positions floor(P*7/16), floor(P*8/16) and floor(P*9/16), where P = 16*M+F. Position 0 is the first input clock of the bit. With M=5 and F=4 (P=84) the samples fall on positions 36, 42 and 47, so a disturbance on position 45 is not seen.
- R3: With a zero fraction the sample spacing is uniform. With M=5 and F=0 the samples fall on positions 35, 40 and 45, so a disturbance on position 47 is not seen.
- R4: Each bit value is the majority of its three samples. A single wrong sample does not change the bit; two wrong samples do.
- R5: `rx_noise` is 1 for a frame when, in any bit of that frame (start, data or stop), the three samples were not all equal.
- R6: A frame begins on a falling edge of the line after a two-flop synchronizer. If the start bit's majority is high, the start is dropped, no byte is produced and the receiver waits for a new falling edge.
- R7: The position count restarts at every bit boundary. The sample positions of the last bit of a frame are therefore the same as those of the first.
- R8: Data bits arrive LSB first. `rx_valid` is high for exactly one cycle per frame. `rx_data`, `rx_ferr` and `rx_noise` change only together with `rx_valid` and hold their values until the next frame. The receiver accepts a new start bit that directly follows a stop bit.
- R9: If the stop bit's majority is low, `rx_ferr` is 1 and the byte is still presented with `rx_valid`.
- R10: While reset is asserted and after it is released, `rx_valid`, `rx_data`, `rx_ferr` and `rx_noise` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| div_mant | input | 12 | Whole part of the divisor (clocks per sixteenth of a bit) |
| div_frac | input | 4 | Fractional part of the divisor in sixteenths |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a new byte |
| rx_ferr | output | 1 | Stop bit was sampled low |
| rx_noise | output | 1 | Sample disagreement somewhere in the frame |

## Verification
The hardest case to reach from the ports is the uneven spacing. A disturbance only shows up if it lands on one exact input clock inside a bit, and the same clock is sampled under one divisor but not under another. The stimulus drives the line one input clock per slot and inverts single slots at chosen offsets. With the divisor at 5.25 it aims at positions 36, 42, 45 and 47, and with the divisor at 5.0 it aims at 45 and 47. Whether the noise flag rises then shows which instants were sampled. Pairs of inverted slots in one bit, a short low pulse that must not start a frame, and a disturbance in the stop bit of a long-divisor frame cover the voting, start qualification and per-bit restart.

// File: rtl/frac_uart_rx_pkg.sv
package frac_uart_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/frac_uart_rx_sync.sv
// Input synchronizer with falling-edge detect on the synchronized level.
module frac_uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic fall
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_regs_t;

    sync_regs_t s_d, s_q;

    always_comb begin
        s_d.chain = {s_q.chain[STAGES-2:0], din};
        s_d.prev  = s_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign level = s_q.chain[STAGES-1];
    assign fall  = s_q.prev & ~s_q.chain[STAGES-1];
endmodule

// File: rtl/frac_uart_rx_pos.sv
// Bit length and the three truncated mid-bit sample positions.
module frac_uart_rx_pos #(
    parameter int MANT_W = 12,
    parameter int FRAC_W = 4,
    parameter int DIV_W  = MANT_W + FRAC_W
) (
    input  logic [MANT_W-1:0]         mant,
    input  logic [FRAC_W-1:0]         frac,
    output logic [DIV_W-1:0]          bit_len,
    output logic [2:0][DIV_W-1:0]     pos
);
    localparam int PROD_W = DIV_W + FRAC_W + 4;
    localparam int FIRST_K = 7;

    logic [MANT_W-1:0] mant_eff;

    assign mant_eff = (mant == '0) ? MANT_W'(1) : mant;
    assign bit_len  = {mant_eff, frac};

    for (genvar k = 0; k < 3; k++) begin : g_pos
        logic [PROD_W-1:0] prod;
        assign prod   = PROD_W'(bit_len) * PROD_W'(FIRST_K + k);
        assign pos[k] = DIV_W'(prod >> FRAC_W);
    end
endmodule

// File: rtl/frac_uart_rx_vote.sv
// Two-of-three vote and disagreement detect.
module frac_uart_rx_vote (
    input  logic [2:0] smp,
    output logic       bit_val,
    output logic       disagree
);
    assign bit_val  = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
    assign disagree = (|smp) & ~(&smp);
endmodule

// File: rtl/frac_uart_rx.sv
module frac_uart_rx #(
    parameter int MANT_W      = 12,
    parameter int FRAC_W      = 4,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic [MANT_W-1:0] div_mant,
    input  logic [FRAC_W-1:0] div_frac,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_ferr,
    output logic              rx_noise
);
    import frac_uart_rx_pkg::*;

    localparam int DIV_W = MANT_W + FRAC_W;
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        rx_state_e         st;
        logic [DIV_W-1:0]  cnt;
        logic [BIT_W-1:0]  bitn;
        logic [1:0]        smp;
        logic [DATA_W-1:0] shreg;
        logic              noise_acc;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              ferr;
        logic              noise;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic                  line_lvl;
    logic                  line_fall;
    logic [DIV_W-1:0]      bit_len;
    logic [2:0][DIV_W-1:0] pos_w;
    logic                  vote_bit;
    logic                  vote_dis;
    logic                  hit_a, hit_b, hit_c, bit_end;

    frac_uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_in),
        .level (line_lvl),
        .fall  (line_fall)
    );

    frac_uart_rx_pos #(.MANT_W(MANT_W), .FRAC_W(FRAC_W), .DIV_W(DIV_W)) u_pos (
        .mant    (div_mant),
        .frac    (div_frac),
        .bit_len (bit_len),
        .pos     (pos_w)
    );

    frac_uart_rx_vote u_vote (
        .smp      ({line_lvl, r_q.smp[1], r_q.smp[0]}),
        .bit_val  (vote_bit),
        .disagree (vote_dis)
    );

    assign hit_a   = (r_q.cnt == pos_w[0]);
    assign hit_b   = (r_q.cnt == pos_w[1]);
    assign hit_c   = (r_q.cnt == pos_w[2]);
    assign bit_end = (r_q.cnt == bit_len - DIV_W'(1));

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        if (r_q.st == RX_IDLE) begin
            // The edge cycle itself is position 0 of the start bit.
            if (line_fall) begin
                r_d.st        = RX_START;
                r_d.cnt       = DIV_W'(1);
                r_d.noise_acc = 1'b0;
            end
        end else begin
            r_d.cnt = bit_end ? '0 : r_q.cnt + DIV_W'(1);
            if (hit_a) r_d.smp[0] = line_lvl;
            if (hit_b) r_d.smp[1] = line_lvl;
            if (hit_c) begin
                r_d.noise_acc = r_q.noise_acc | vote_dis;
                case (r_q.st)
                    RX_START: if (vote_bit) r_d.st = RX_IDLE;
                    RX_DATA:  r_d.shreg = {vote_bit, r_q.shreg[DATA_W-1:1]};
                    RX_STOP: begin
                        r_d.data  = r_q.shreg;
                        r_d.valid = 1'b1;
                        r_d.ferr  = ~vote_bit;
                        r_d.noise = r_q.noise_acc | vote_dis;
                        r_d.st    = RX_IDLE;
                    end
                    default: ;
                endcase
            end
            if (bit_end) begin
                case (r_q.st)
                    RX_START: begin
                        r_d.st   = RX_DATA;
                        r_d.bitn = '0;
                    end
                    RX_DATA: begin
                        if (r_q.bitn == BIT_W'(DATA_W - 1)) r_d.st = RX_STOP;
                        else                                r_d.bitn = r_q.bitn + BIT_W'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= RX_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rx_data  = r_q.data;
    assign rx_valid = r_q.valid;
    assign rx_ferr  = r_q.ferr;
    assign rx_noise = r_q.noise;
endmodule

// File: rtl/frac_uart_rx_checker.sv
module frac_uart_rx_checker #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic [DATA_W-1:0]                  rx_data,
    input logic                               rx_valid,
    input logic                               rx_ferr,
    input logic                               rx_noise,
    input frac_uart_rx_pkg::rx_state_e        st,
    input logic [DIV_W-1:0]                   cnt,
    input logic [DIV_W-1:0]                   bit_len,
    input logic [2:0][DIV_W-1:0]              pos
);
    import frac_uart_rx_pkg::*;

    assert_valid_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_outputs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_data) && $stable(rx_ferr) && $stable(rx_noise)));

    assert_valid_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ($past(st) == RX_STOP));

    assert_cnt_in_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st != RX_IDLE) |-> (cnt < bit_len));

    assert_pos_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos[0] < pos[1]) && (pos[1] < pos[2]) && (pos[2] < bit_len));

    assert_start_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == RX_IDLE) |=> ((st == RX_IDLE) || (st == RX_START && cnt == DIV_W'(1))));
endmodule

bind frac_uart_rx frac_uart_rx_checker #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .rx_ferr  (rx_ferr),
    .rx_noise (rx_noise),
    .st       (r_q.st),
    .cnt      (r_q.cnt),
    .bit_len  (bit_len),
    .pos      (pos_w)
);

// File: tb/frac_uart_rx_bench.sv
`timescale 1ns/1ps
module frac_uart_rx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_in = 1'b1;
    logic [11:0] div_mant = 12'd5;
    logic [3:0]  div_frac = 4'd0;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_ferr;
    logic        rx_noise;

    always #2.5 clk = ~clk;

    frac_uart_rx u_frac_uart_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_in    (rx_in),
        .div_mant (div_mant),
        .div_frac (div_frac),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_ferr  (rx_ferr),
        .rx_noise (rx_noise)
    );

    typedef struct {
        logic [7:0] data;
        logic       ferr;
        logic       noise;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic int period(int m, int f);
        return ((m == 0) ? 1 : m) * 16 + f;
    endfunction

    // Drive one frame, one line slot per input clock; slots g0/g1 are inverted.
    task automatic send_frame(int m, int f, logic [7:0] b, logic stop_lvl,
                              int g0, int g1, int gap, string tag);
        int   p;
        logic base [10];
        logic [7:0] exp_byte;
        logic exp_noise, start_maj, stop_maj;
        exp_t e;
        p = period(m, f);
        base[0] = 1'b0;
        for (int i = 0; i < 8; i++) base[1+i] = b[i];
        base[9] = stop_lvl;
        exp_byte = '0; exp_noise = 1'b0; start_maj = 1'b0; stop_maj = 1'b0;
        for (int bb = 0; bb < 10; bb++) begin
            int ones;
            logic maj;
            ones = 0;
            for (int k = 7; k <= 9; k++) begin
                int slot;
                slot = bb * p + ((p * k) >> 4);
                ones += int'(base[bb] ^ ((slot == g0) || (slot == g1)));
            end
            maj = (ones >= 2);
            if (ones != 0 && ones != 3) exp_noise = 1'b1;
            if (bb == 0) start_maj = maj;
            else if (bb == 9) stop_maj = maj;
            else exp_byte[bb-1] = maj;
        end
        if (!start_maj) begin
            e.data = exp_byte; e.ferr = ~stop_maj; e.noise = exp_noise; e.tag = tag;
            q.push_back(e);
        end
        @(negedge clk);
        div_mant = 12'(m);
        div_frac = 4'(f);
        for (int s = 0; s < 10 * p; s++) begin
            rx_in = base[s / p] ^ ((s == g0) || (s == g1));
            @(negedge clk);
        end
        rx_in = 1'b1;
        repeat (gap) @(negedge clk);
    endtask

    task automatic send_runt(int m, int f, int low_len, int tail);
        @(negedge clk);
        div_mant = 12'(m);
        div_frac = 4'(f);
        rx_in = 1'b0;
        repeat (low_len) @(negedge clk);
        rx_in = 1'b1;
        repeat (tail) @(negedge clk);
    endtask

    // Monitor: compare each strobe against the scoreboard.
    initial begin
        bit prev_v;
        prev_v = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_v && rx_valid)
                    chk(1'b0, "R8", "valid longer than one cycle", 1, 0);
                if (rx_valid) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R6", "unexpected byte", int'(rx_data), 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        chk(rx_data == e.data, e.tag, "data", int'(rx_data), int'(e.data));
                        chk(rx_ferr == e.ferr, e.tag, "framing flag", int'(rx_ferr), int'(e.ferr));
                        chk(rx_noise == e.noise, e.tag, "noise flag", int'(rx_noise), int'(e.noise));
                    end
                end
                prev_v = rx_valid;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual run still busy, expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(rx_valid == 1'b0, "R10", "valid in reset", int'(rx_valid), 0);
        chk(rx_data == 8'h00, "R10", "data in reset", int'(rx_data), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(rx_ferr == 1'b0, "R10", "ferr after reset", int'(rx_ferr), 0);
        chk(rx_noise == 1'b0, "R10", "noise after reset", int'(rx_noise), 0);
        chk(rx_valid == 1'b0, "R10", "valid after reset", int'(rx_valid), 0);

        // Uniform spacing at 5.0: positions 35, 40, 45.
        send_frame(5, 0, 8'hA5, 1'b1, -1, -1, 100, "R3");
        send_frame(5, 0, 8'h96, 1'b1, 4*80+45, -1, 100, "R3");
        send_frame(5, 0, 8'h96, 1'b1, 4*80+47, -1, 100, "R3");
        // Fractional 5.25: positions 36, 42, 47.
        send_frame(5, 4, 8'h3C, 1'b1, -1, -1, 100, "R1");
        send_frame(5, 4, 8'h3C, 1'b1, 3*84+47, -1, 100, "R2");
        send_frame(5, 4, 8'h3C, 1'b1, 3*84+45, -1, 100, "R2");
        send_frame(5, 4, 8'h3C, 1'b1, 3*84+37, -1, 100, "R2");
        // Majority: two flipped samples flip the bit, one does not.
        send_frame(5, 4, 8'h00, 1'b1, 1*84+36, 1*84+42, 100, "R4");
        send_frame(5, 4, 8'h00, 1'b1, 6*84+42, -1, 100, "R4");
        // Stop low.
        send_frame(5, 4, 8'h81, 1'b0, -1, -1, 100, "R9");
        // Single disturbances in stop and start bits.
        send_frame(5, 4, 8'h55, 1'b1, 9*84+36, -1, 100, "R5");
        send_frame(5, 4, 8'h55, 1'b1, 42, -1, 100, "R5");
        // Short low pulse must not start a frame, then a clean one.
        send_runt(5, 4, 10, 1200);
        send_frame(5, 4, 8'h5A, 1'b1, -1, -1, 100, "R6");
        // Whole part 0 treated as 1: 24-clock bit.
        send_frame(0, 8, 8'hC3, 1'b1, -1, -1, 60, "R1");
        // Long divisor 7.75, disturbance on last sample of the stop bit.
        send_frame(7, 12, 8'hFF, 1'b1, 9*124+69, -1, 200, "R7");
        // Back-to-back frames with no idle between stop and start.
        send_frame(6, 2, 8'h12, 1'b1, -1, -1, 0, "R8");
        send_frame(6, 2, 8'hED, 1'b1, -1, -1, 200, "R8");
        chk(rx_data == 8'hED, "R8", "data held after frame", int'(rx_data), 'hED);

        repeat (50) @(negedge clk);
        chk(q.size() == 0, "R6", "bytes still expected", q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule